// File: doc/BRIEF.md
# Per-Frame Acoustic Score Cache

This block sits between the search stage of a speech decoder and its Gaussian mixture evaluator. Every candidate arc arrives carrying an acoustic label (the index of the mixture density it consumes), its transition weight and the score of the hypothesis it leaves. Many arcs in one frame share a label. The block therefore keeps the log-likelihoods it has already obtained in a small direct-mapped table. When a label is found in the table, the block emits the arc's total score one cycle later and does not call the evaluator.

When the label is not present, the block issues a single evaluation request and holds its input handshake low until the result returns. It then writes the value into the table and emits the total. Every score is the sum of log-likelihood, arc weight and prior score, clipped at the largest value the score width can hold. A frame-start pulse empties the table and clears the per-frame hit and miss tallies, because the feature vector, and with it every likelihood, changes at that point.

Top module: `gsc_score_cache`

## Requirements
- R1: After reset, in_ready is 1, out_valid and eval_req are 0, and hit_count and miss_count are 0.
- R2: If an accepted arc's table set (the low SET_W bits of in_idx) holds a valid entry whose stored tag equals the remaining upper bits, then out_valid is 1 with out_hit=1 in the cycle after acceptance, and no evaluation is requested.
- R3: out_score equals log-likelihood + in_weight + in_prior, treated as unsigned, and is held at 2^SCORE_W-1 whenever the true sum exceeds that value.
- R4: On a miss, eval_req rises in the cycle after acceptance with eval_idx equal to the arc's in_idx. Both stay unchanged until eval_done is sampled high, and in_ready is 0 throughout.
- R5: In the cycle after eval_done is sampled with eval_req high, out_valid is 1 with out_hit=0 and a score built from eval_ll. The entry is filled, so a later arc with the same label hits.
- R6: The table is direct-mapped. An arc whose label has the same low SET_W bits but a different tag replaces the earlier entry, and the earlier label then misses.
- R7: A cycle with frame_start high forces in_ready to 0, invalidates every entry, and leaves hit_count and miss_count at 0 in the next cycle.
- R8: If frame_start arrives while a miss is outstanding, the pending arc still receives its score, but the returned likelihood is not stored.
- R9: hit_count and miss_count each increase by one per accepted hit or miss respectively, and stop at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| in_valid | input | 1 | Arc present on the inputs |
| in_ready | output | 1 | Block can take an arc this cycle |
| in_idx | input | IDX_W | Acoustic label of the arc |
| in_weight | input | SCORE_W | Arc transition weight |
| in_prior | input | SCORE_W | Score of the source hypothesis |
| out_valid | output | 1 | One-cycle strobe for a finished arc score |
| out_score | output | SCORE_W | Saturated total score |
| out_hit | output | 1 | 1 if the score came from the table |
| eval_req | output | 1 | Evaluation request, held until answered |
| eval_idx | output | IDX_W | Label to evaluate |
| eval_done | input | 1 | Evaluator result valid |
| eval_ll | input | SCORE_W | Evaluated log-likelihood |
| hit_count | output | CNT_W | Hits in the current frame |
| miss_count | output | CNT_W | Misses in the current frame |

## Verification
The bench builds the block with IDX_W=4, SET_W=2, SCORE_W=8 and CNT_W=4. With these values, all sixteen labels can be swept, and every set sees all four of its tags, which exercises both eviction and refill. An 8-bit score makes saturation frequent under ordinary weights. A 4-bit counter reaches its ceiling after fifteen arcs in one frame. The evaluator model varies its answer latency from zero to three cycles, and one scenario places a frame pulse inside an outstanding miss.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic {
    GSC_IDLE = 1'b0,
    GSC_WAIT = 1'b1
  } gsc_state_e;
endpackage

// File: rtl/gsc_sat_add3.sv
module gsc_sat_add3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  localparam int SUM_W = W + 2;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {2'b00, a} + {2'b00, b} + {2'b00, c};
    if (|sum[SUM_W-1:W]) y = '1;
    else                 y = sum[W-1:0];
  end
endmodule

// File: rtl/gsc_store.sv
module gsc_store #(
  parameter int IDX_W   = 12,
  parameter int SET_W   = 8,
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_hit,
  output logic [SCORE_W-1:0] rd_ll,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [SCORE_W-1:0] wr_ll
);
  localparam int SETS  = 2 ** SET_W;
  localparam int TAG_W = IDX_W - SET_W;

  logic [SET_W-1:0] rd_set, wr_set;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_set = rd_idx[SET_W-1:0];
  assign rd_tag = rd_idx[IDX_W-1:SET_W];
  assign wr_set = wr_idx[SET_W-1:0];
  assign wr_tag = wr_idx[IDX_W-1:SET_W];

  logic [SETS-1:0]    vld_vec;
  logic [TAG_W-1:0]   tag_arr [SETS];
  logic [SCORE_W-1:0] ll_arr  [SETS];

  for (genvar e = 0; e < SETS; e++) begin : g_ent
    logic               v_q, v_d;
    logic               we;
    logic [TAG_W-1:0]   tag_q;
    logic [SCORE_W-1:0] ll_q;

    assign we = wr_en && !flush && (wr_set == SET_W'(e));

    always_comb begin
      v_d = v_q;
      if (flush)   v_d = 1'b0;
      else if (we) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q <= wr_tag;
        ll_q  <= wr_ll;
      end
    end

    assign vld_vec[e] = v_q;
    assign tag_arr[e] = tag_q;
    assign ll_arr[e]  = ll_q;
  end

  assign rd_hit = vld_vec[rd_set] && (tag_arr[rd_set] == rd_tag);
  assign rd_ll  = ll_arr[rd_set];
endmodule

// File: rtl/gsc_stats.sv
module gsc_stats #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hit_inc,
  input  logic             miss_inc,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int NCNT = 2;

  logic [NCNT-1:0]            inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_all;

  assign inc = {miss_inc, hit_inc};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [CNT_W-1:0] q, d;

    always_comb begin
      d = q;
      if (clear)                  d = '0;
      else if (inc[g] && ~&q)     d = q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign cnt_all[g] = q;
  end

  assign hit_count  = cnt_all[0];
  assign miss_count = cnt_all[1];
endmodule

// File: rtl/gsc_score_cache.sv
module gsc_score_cache
  import gsc_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int SET_W   = 8,
  parameter int SCORE_W = 16,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_idx,
  input  logic [SCORE_W-1:0] in_weight,
  input  logic [SCORE_W-1:0] in_prior,
  output logic               out_valid,
  output logic [SCORE_W-1:0] out_score,
  output logic               out_hit,
  output logic               eval_req,
  output logic [IDX_W-1:0]   eval_idx,
  input  logic               eval_done,
  input  logic [SCORE_W-1:0] eval_ll,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  gsc_state_e         state_q, state_d;
  logic               stale_q, stale_d;
  logic               ovld_q, ovld_d;
  logic               ohit_q, ohit_d;
  logic [SCORE_W-1:0] oscore_q, oscore_d;
  logic [IDX_W-1:0]   pidx_q;
  logic [SCORE_W-1:0] pw_q, pp_q;

  logic               accept, lk_hit, fill_en, pend_en, out_en;
  logic [SCORE_W-1:0] lk_ll, op_ll, op_w, op_p, sum;
  logic               busy;

  assign busy     = (state_q == GSC_WAIT);
  assign in_ready = !busy && !frame_start;
  assign accept   = in_valid && in_ready;

  gsc_store #(
    .IDX_W(IDX_W), .SET_W(SET_W), .SCORE_W(SCORE_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flush  (frame_start),
    .rd_idx (in_idx),
    .rd_hit (lk_hit),
    .rd_ll  (lk_ll),
    .wr_en  (fill_en),
    .wr_idx (pidx_q),
    .wr_ll  (eval_ll)
  );

  // one adder serves both the lookup path and the refill path
  assign op_ll = busy ? eval_ll : lk_ll;
  assign op_w  = busy ? pw_q    : in_weight;
  assign op_p  = busy ? pp_q    : in_prior;

  gsc_sat_add3 #(.W(SCORE_W)) u_add (
    .a (op_ll),
    .b (op_w),
    .c (op_p),
    .y (sum)
  );

  gsc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear      (frame_start),
    .hit_inc    (accept && lk_hit),
    .miss_inc   (accept && !lk_hit),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  assign pend_en = accept && !lk_hit;
  assign out_en  = (accept && lk_hit) || (busy && eval_done);
  assign fill_en = busy && eval_done && !stale_q && !frame_start;

  always_comb begin
    state_d  = state_q;
    stale_d  = stale_q;
    ovld_d   = 1'b0;
    ohit_d   = ohit_q;
    oscore_d = oscore_q;
    unique case (state_q)
      GSC_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            ovld_d   = 1'b1;
            ohit_d   = 1'b1;
            oscore_d = sum;
          end else begin
            state_d = GSC_WAIT;
            stale_d = 1'b0;
          end
        end
      end
      GSC_WAIT: begin
        if (frame_start) stale_d = 1'b1;
        if (eval_done) begin
          ovld_d   = 1'b1;
          ohit_d   = 1'b0;
          oscore_d = sum;
          state_d  = GSC_IDLE;
        end
      end
      default: state_d = GSC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= GSC_IDLE;
      stale_q <= 1'b0;
      ovld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stale_q <= stale_d;
      ovld_q  <= ovld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (out_en) begin
      ohit_q   <= ohit_d;
      oscore_q <= oscore_d;
    end
    if (pend_en) begin
      pidx_q <= in_idx;
      pw_q   <= in_weight;
      pp_q   <= in_prior;
    end
  end

  assign out_valid = ovld_q;
  assign out_hit   = ohit_q;
  assign out_score = oscore_q;
  assign eval_req  = busy;
  assign eval_idx  = pidx_q;
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int IDX_W   = 12,
  parameter int SCORE_W = 16,
  parameter int CNT_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_hit,
  input logic               eval_req,
  input logic [IDX_W-1:0]   eval_idx,
  input logic               eval_done,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && !eval_done) |=> (eval_req && $stable(eval_idx)));

  // R4
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |-> !in_ready);

  // R7
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (hit_count == '0 && miss_count == '0));

  // R5
  fill_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && eval_done) |=> (out_valid && !out_hit));

  // R2
  accept_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((out_valid && out_hit) || (eval_req && !out_valid)));

  // R9
  hit_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (hit_count >= $past(hit_count)));

  // R9
  miss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (miss_count >= $past(miss_count)));
endmodule

bind gsc_score_cache gsc_checker #(
  .IDX_W(IDX_W), .SCORE_W(SCORE_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_hit     (out_hit),
  .eval_req    (eval_req),
  .eval_idx    (eval_idx),
  .eval_done   (eval_done),
  .hit_count   (hit_count),
  .miss_count  (miss_count)
);

// File: tb/gsc_score_cache_tb.sv
module gsc_score_cache_tb;
  localparam int IW = 4;
  localparam int SW = 2;
  localparam int VW = 8;
  localparam int CW = 4;
  localparam int NS = 2 ** SW;
  localparam int VMAX = 2 ** VW - 1;
  localparam int CMAX = 2 ** CW - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start;
  logic          in_valid;
  logic          in_ready;
  logic [IW-1:0] in_idx;
  logic [VW-1:0] in_weight, in_prior;
  logic          out_valid;
  logic [VW-1:0] out_score;
  logic          out_hit;
  logic          eval_req;
  logic [IW-1:0] eval_idx;
  logic          eval_done;
  logic [VW-1:0] eval_ll;
  logic [CW-1:0] hit_count, miss_count;

  always #5 clk = ~clk;

  gsc_score_cache #(
    .IDX_W(IW), .SET_W(SW), .SCORE_W(VW), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
    .in_weight(in_weight), .in_prior(in_prior),
    .out_valid(out_valid), .out_score(out_score), .out_hit(out_hit),
    .eval_req(eval_req), .eval_idx(eval_idx), .eval_done(eval_done),
    .eval_ll(eval_ll), .hit_count(hit_count), .miss_count(miss_count)
  );

  int total = 0;
  int bad = 0;
  int lat = 0;
  int evals = 0;
  logic [IW-1:0] cur_idx = '0;

  bit            mv  [NS];
  logic [IW-SW-1:0] mt [NS];
  logic [VW-1:0] mll [NS];
  int eh = 0;
  int em = 0;

  function automatic logic [VW-1:0] llf(logic [IW-1:0] i);
    return VW'(int'(i) * 29 + 7);
  endfunction

  function automatic int sat3(int a, int b, int c);
    int s = a + b + c;
    return (s > VMAX) ? VMAX : s;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // evaluator model with programmable latency
  initial begin
    eval_done = 1'b0;
    eval_ll   = '0;
    forever begin
      @(negedge clk);
      eval_done = 1'b0;
      if (eval_req) begin
        chk("R4 eval_idx", int'(eval_idx), int'(cur_idx));
        chk("R4 in_ready low while waiting", int'(in_ready), 0);
        repeat (lat) @(negedge clk);
        eval_ll   = llf(eval_idx);
        eval_done = 1'b1;
        evals++;
      end
    end
  end

  task automatic send_arc(logic [IW-1:0] idx, logic [VW-1:0] w, logic [VW-1:0] p, bit fill);
    logic [SW-1:0] s = idx[SW-1:0];
    bit exp_hit = mv[s] && (mt[s] == idx[IW-1:SW]);
    int ll = exp_hit ? int'(mll[s]) : int'(llf(idx));
    int e0 = evals;
    int n = 0;
    cur_idx = idx;
    @(negedge clk);
    in_valid  = 1'b1;
    in_idx    = idx;
    in_weight = w;
    in_prior  = p;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (exp_hit) eh = (eh < CMAX) ? eh + 1 : CMAX;
    else         em = (em < CMAX) ? em + 1 : CMAX;
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_hit) begin
      chk("R2 out_valid one cycle after hit", int'(out_valid), 1);
    end else begin
      while (!out_valid && n < 20) begin
        @(negedge clk);
        n++;
      end
    end
    chk(exp_hit ? "R2 hit flag" : "R6 R5 miss flag", int'(out_hit), int'(exp_hit));
    chk("R3 score sum", int'(out_score), sat3(ll, int'(w), int'(p)));
    chk(exp_hit ? "R2 no evaluation on hit" : "R4 one evaluation on miss",
        evals - e0, exp_hit ? 0 : 1);
    chk("R9 hit_count", int'(hit_count), eh);
    chk("R9 miss_count", int'(miss_count), em);
    if (!exp_hit && fill) begin
      mv[s]  = 1'b1;
      mt[s]  = idx[IW-1:SW];
      mll[s] = llf(idx);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < NS; k++) mv[k] = 1'b0;
    eh = 0;
    em = 0;
  endtask

  task automatic new_frame();
    @(negedge clk);
    frame_start = 1'b1;
    #1;
    chk("R7 in_ready low on frame pulse", int'(in_ready), 0);
    @(negedge clk);
    frame_start = 1'b0;
    clear_model();
    chk("R7 hit_count cleared", int'(hit_count), 0);
    chk("R7 miss_count cleared", int'(miss_count), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    frame_start = 1'b0;
    in_valid    = 1'b0;
    in_idx      = '0;
    in_weight   = '0;
    in_prior    = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 eval_req", int'(eval_req), 0);
    chk("R1 hit_count", int'(hit_count), 0);
    chk("R1 miss_count", int'(miss_count), 0);

    // R6: cycling all labels evicts within each set
    for (int f = 0; f < 2; f++) begin
      new_frame();
      for (int pass = 0; pass < 2; pass++) begin
        for (int i = 0; i < 16; i++) begin
          lat = (i + pass + f) % 4;
          send_arc(IW'(i), VW'(i * 13 + pass * 50), VW'(i * 7 + 90 * pass + f * 40), 1'b1);
        end
      end
    end

    // R2 R5 R3: refill then hit, with sums crossing the ceiling
    new_frame();
    for (int i = 0; i < 16; i++) begin
      lat = i % 4;
      send_arc(IW'(i), VW'(i * 17), VW'(200 - i * 3), 1'b1);
      send_arc(IW'(i), VW'(i * 5 + 1), VW'(i * 11), 1'b1);
    end

    // R3: exact boundary below the ceiling
    new_frame();
    lat = 1;
    send_arc(4'd9, VW'(254 - int'(llf(4'd9))), 8'd0, 1'b1);
    send_arc(4'd9, VW'(255 - int'(llf(4'd9))), 8'd0, 1'b1);
    send_arc(4'd9, VW'(255 - int'(llf(4'd9))), 8'd1, 1'b1);

    // R9: counter saturation within one frame
    new_frame();
    send_arc(4'd6, 8'd3, 8'd4, 1'b1);
    for (int k = 0; k < 20; k++) send_arc(4'd6, VW'(k), VW'(k * 3), 1'b1);

    // R7: entries invalidated by the frame pulse
    new_frame();
    send_arc(4'd6, 8'd3, 8'd4, 1'b1);

    // R8: frame pulse during an outstanding miss
    new_frame();
    lat = 3;
    fork
      send_arc(4'd5, 8'd10, 8'd20, 1'b0);
      begin
        repeat (2) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        clear_model();
      end
    join
    @(negedge clk);
    chk("R8 counters cleared by mid-miss pulse", int'(hit_count) + int'(miss_count), 0);
    lat = 0;
    send_arc(4'd5, 8'd1, 8'd2, 1'b1);
    send_arc(4'd5, 8'd2, 8'd2, 1'b1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule